// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block sits beside a single-rank SDRAM command bus and watches it every clock. It decodes each command, keeps per-bank state (open or closed) for a parameterised number of banks, and runs down-counters for the spacing rules between activate, column access, precharge and refresh commands. Any command that breaks a state or spacing rule produces a one-cycle error report that carries a rule code and the bank involved.

The monitor has no effect on the bus. It is instantiated next to a memory controller, or in a chip-level test environment, with the command pins, the bank-select pins and two slices of the address bus connected to it. The slices are the auto-precharge / precharge-all bit and the three burst-length bits of the mode-set field. The timing limits are parameters given in clock cycles. A command that breaks a rule still updates the tracked state as if the memory had carried it out, so one mistake does not cause a chain of later false reports.

Auto-precharge is modelled for each bank. A column access with the auto-precharge bit set locks its bank for the burst length. The access closes the bank and sets how long the bank must wait before the next activate. For a write this wait includes the write-recovery cycles. The access also checks that the implied internal precharge does not begin too soon after the activate.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only when `cke` was high in the previous cycle and `cs_n` is low. With `{ras_n,cas_n,we_n}` the encodings are: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set. A deselect (`cs_n` high), 111 or 110 changes no state and never raises an error.
- R2: An error appears on `err_valid`/`err_code`/`err_bank` in the cycle after the offending command and lasts exactly one cycle. Only one code is reported per command, chosen by the fixed priority given in R3 to R12. `err_code` is 0 when there is no error.
- R3: An activate to a bank that is already open reports code 1.
- R4: An activate fewer than TRC cycles after the previous activate of the same bank reports code 2. An activate fewer than TRRD cycles after an activate to a different bank reports code 3. The priority for an activate is code 1, then 2, then 4, then 3.
- R5: An activate before the bank's precharge wait has expired (TRP cycles after a precharge that closed it) reports code 4.
- R6: A read or write to a closed bank reports code 5. A read or write fewer than TRCD cycles after that bank's activate reports code 6.
- R7: A precharge with `addr_ap` high closes every open bank. With `addr_ap` low it closes only the bank on `ba`. A precharge that closes a bank fewer than TRAS cycles after its activate reports code 7, naming the lowest such bank. A precharge of a bank that is already closed has no effect.
- R8: A read or write with `addr_ap` high requests auto-precharge. When the burst length is full page this reports code 8, and the access is carried out without auto-precharge.
- R9: For BL cycles from a read or write with auto-precharge, any read, write or single precharge to that bank reports code 9, as does a precharge-all while any bank is locked. This check takes priority over all other column checks.
- R10: After a write with auto-precharge, an activate to that bank is allowed only from BL-1+TDPL+TRP cycles after the write command. After a read with auto-precharge it is allowed from BL+TRP cycles after the read. An earlier activate reports code 4.
- R11: The internal precharge of an auto-precharge access begins BL cycles after a read, or BL-1+TDPL cycles after a write. If this start would fall fewer than TRAS cycles after the activate, the access reports code 7.
- R12: A refresh command (auto-refresh, or self-refresh entry where `cke` goes low on the same command) while any bank is open or still inside its precharge wait reports code 10, naming the lowest such bank.
- R13: A command that raised an error still updates the bank state and the counters as if it had executed.
- R14: A mode set loads the burst length from `mode_bl`. Codes 0 to 3 give 1, 2, 4 and 8. Any code with bit 2 set means full page. After reset the code is BL_RST_CODE (default 2, which gives 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr_ap | input | 1 | Auto-precharge / precharge-all address bit |
| mode_bl | input | 3 | Burst-length bits of the address bus |
| err_valid | output | 1 | One-cycle violation pulse |
| err_code | output | 4 | Rule code (0 when no violation) |
| err_bank | output | BA_W | Bank the violation refers to |

## Verification
The bench drives each rule exactly at its boundary cycle and one cycle short of it. An off-by-one counter load would show up as a false error or a missed error at these points. Several cases rely on state being updated after a violation. A precharge-all that trips TRAS must still close both banks, so a later activate is clean. An illegal full-page auto-precharge must leave the bank open, so a following plain read is clean. A monitor that dropped the failing command would report spurious codes 1 or 5 in these places. The auto-precharge lock is probed both inside and just after its BL window, and write recovery is probed one cycle before and exactly at the point the next activate becomes legal. A decoder that ignored the registered clock enable would flag the activate issued right after self-refresh entry.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_REF  = 3'd5,
    OP_MODE = 3'd6
  } op_e;

  typedef enum logic [3:0] {
    E_NONE     = 4'd0,
    E_ACT_OPEN = 4'd1,
    E_ACT_TRC  = 4'd2,
    E_ACT_TRRD = 4'd3,
    E_ACT_TRP  = 4'd4,
    E_RW_IDLE  = 4'd5,
    E_RW_TRCD  = 4'd6,
    E_TRAS     = 4'd7,
    E_AP_FULL  = 4'd8,
    E_AP_BUSY  = 4'd9,
    E_REF_BUSY = 4'd10
  } err_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output op_e  op
);
  // commands count only when the clock was enabled one cycle earlier
  logic cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= cke;
  end

  always_comb begin
    op = OP_NONE;
    if (cke_q && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  op = OP_ACT;
        3'b101:  op = OP_RD;
        3'b100:  op = OP_WR;
        3'b010:  op = OP_PRE;
        3'b001:  op = OP_REF;
        3'b000:  op = OP_MODE;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int BL_W  = 4,
  parameter int TRCD  = 2,
  parameter int TRAS  = 5,
  parameter int TRC   = 7,
  parameter int TRP   = 2,
  parameter int TDPL  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  op_e              op,
  input  logic             pre_all,
  input  logic             ap_en,
  input  logic [BL_W-1:0]  bl_len,
  output logic             is_open,
  output logic             rcd_done,
  output logic             rc_done,
  output logic             rp_done,
  output logic             ap_busy,
  output logic [CNT_W-1:0] ras_left
);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(TRCD - 1);
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(TRAS - 1);
  localparam logic [CNT_W-1:0] L_RC  = CNT_W'(TRC - 1);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(TRP - 1);

  logic [CNT_W-1:0] rcd_c, ras_c, rc_c, rp_c, ap_c;
  logic [CNT_W-1:0] bl_c, rp_ap_rd, rp_ap_wr, rp_ap;

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] umax(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign bl_c     = CNT_W'(bl_len);
  assign rp_ap_rd = bl_c + CNT_W'(TRP - 1);
  assign rp_ap_wr = bl_c + CNT_W'(TDPL + TRP - 2);
  assign rp_ap    = (op == OP_RD) ? rp_ap_rd : rp_ap_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      rcd_c   <= '0;
      ras_c   <= '0;
      rc_c    <= '0;
      rp_c    <= '0;
      ap_c    <= '0;
    end else begin
      rcd_c <= dec(rcd_c);
      ras_c <= dec(ras_c);
      rc_c  <= dec(rc_c);
      rp_c  <= dec(rp_c);
      ap_c  <= dec(ap_c);
      if (op == OP_ACT && sel) begin
        is_open <= 1'b1;
        rcd_c   <= L_RCD;
        ras_c   <= L_RAS;
        rc_c    <= L_RC;
      end else if ((op == OP_RD || op == OP_WR) && sel && ap_en) begin
        is_open <= 1'b0;
        ap_c    <= bl_c - 1'b1;
        rp_c    <= umax(dec(rp_c), rp_ap);
      end else if (op == OP_PRE && (sel || pre_all) && is_open) begin
        is_open <= 1'b0;
        rp_c    <= umax(dec(rp_c), L_RP);
      end
    end
  end

  assign rcd_done = (rcd_c == '0);
  assign rc_done  = (rc_c == '0);
  assign rp_done  = (rp_c == '0);
  assign ap_busy  = (ap_c != '0);
  assign ras_left = ras_c;
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2,
  parameter int CNT_W = 8,
  parameter int BL_W  = 4,
  parameter int TDPL  = 1
) (
  input  op_e                          op,
  input  logic [BA_W-1:0]              ba,
  input  logic                         ap_req,
  input  logic                         full_page,
  input  logic [BL_W-1:0]              bl_len,
  input  logic [BANKS-1:0]             bank_open,
  input  logic [BANKS-1:0]             rcd_done,
  input  logic [BANKS-1:0]             rc_done,
  input  logic [BANKS-1:0]             rp_done,
  input  logic [BANKS-1:0]             ap_busy,
  input  logic [BANKS-1:0][CNT_W-1:0]  ras_left,
  input  logic                         rrd_busy,
  input  logic [BA_W-1:0]              last_act,
  output err_e                         code,
  output logic [BA_W-1:0]              bank
);
  logic [CNT_W-1:0] ap_offs;
  logic             busy_hit, tras_hit, ref_hit;
  logic [BA_W-1:0]  busy_b, tras_b, ref_b;

  // internal precharge start relative to the column command
  assign ap_offs = (op == OP_RD) ? CNT_W'(bl_len)
                                 : CNT_W'(bl_len) + CNT_W'(TDPL - 1);

  always_comb begin
    busy_hit = 1'b0; tras_hit = 1'b0; ref_hit = 1'b0;
    busy_b = '0; tras_b = '0; ref_b = '0;
    for (int b = BANKS - 1; b >= 0; b--) begin
      if (ap_busy[b]) begin
        busy_hit = 1'b1; busy_b = BA_W'(b);
      end
      if (bank_open[b] && ras_left[b] != '0) begin
        tras_hit = 1'b1; tras_b = BA_W'(b);
      end
      if (bank_open[b] || !rp_done[b]) begin
        ref_hit = 1'b1; ref_b = BA_W'(b);
      end
    end
  end

  always_comb begin
    code = E_NONE;
    bank = ba;
    unique case (op)
      OP_ACT: begin
        if (bank_open[ba])                code = E_ACT_OPEN;
        else if (!rc_done[ba])            code = E_ACT_TRC;
        else if (!rp_done[ba])            code = E_ACT_TRP;
        else if (rrd_busy && ba != last_act) code = E_ACT_TRRD;
      end
      OP_RD, OP_WR: begin
        if (ap_busy[ba])                  code = E_AP_BUSY;
        else if (ap_req && full_page)     code = E_AP_FULL;
        else if (!bank_open[ba])          code = E_RW_IDLE;
        else if (!rcd_done[ba])           code = E_RW_TRCD;
        else if (ap_req && ras_left[ba] > ap_offs) code = E_TRAS;
      end
      OP_PRE: begin
        if (ap_req) begin
          if (busy_hit) begin
            code = E_AP_BUSY; bank = busy_b;
          end else if (tras_hit) begin
            code = E_TRAS; bank = tras_b;
          end
        end else begin
          if (ap_busy[ba])                code = E_AP_BUSY;
          else if (bank_open[ba] && ras_left[ba] != '0) code = E_TRAS;
        end
      end
      OP_REF: begin
        if (ref_hit) begin
          code = E_REF_BUSY; bank = ref_b;
        end
      end
      default: code = E_NONE;
    endcase
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int         BANKS       = 4,
  parameter int         CNT_W       = 8,
  parameter int         TRCD        = 2,
  parameter int         TRAS        = 5,
  parameter int         TRC         = 7,
  parameter int         TRP         = 2,
  parameter int         TRRD        = 2,
  parameter int         TDPL        = 1,
  parameter logic [2:0] BL_RST_CODE = 3'd2,
  localparam int        BA_W        = $clog2(BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            addr_ap,
  input  logic [2:0]      mode_bl,
  output logic            err_valid,
  output logic [3:0]      err_code,
  output logic [BA_W-1:0] err_bank
);
  localparam int BL_W = 4;

  op_e                         op;
  logic [2:0]                  bl_code;
  logic [BL_W-1:0]             bl_len;
  logic                        full_page;
  logic                        ap_en;
  logic [BANKS-1:0]            bank_open, rcd_done, rc_done, rp_done, ap_busy;
  logic [BANKS-1:0][CNT_W-1:0] ras_left;
  logic [CNT_W-1:0]            rrd_c;
  logic [BA_W-1:0]             last_act;
  err_e                        code;
  logic [BA_W-1:0]             code_bank;

  sdram_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .op(op)
  );

  // burst length from the mode-set field
  always_ff @(posedge clk) begin
    if (!rst_n)             bl_code <= BL_RST_CODE;
    else if (op == OP_MODE) bl_code <= mode_bl;
  end

  assign full_page = bl_code[2];
  assign bl_len    = BL_W'(1) << bl_code[1:0];
  assign ap_en     = addr_ap && !full_page;

  // activate-to-activate spacing across banks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_c    <= '0;
      last_act <= '0;
    end else if (op == OP_ACT) begin
      rrd_c    <= CNT_W'(TRRD - 1);
      last_act <= ba;
    end else if (rrd_c != '0) begin
      rrd_c    <= rrd_c - 1'b1;
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    sdram_bank_track #(
      .CNT_W(CNT_W), .BL_W(BL_W), .TRCD(TRCD), .TRAS(TRAS),
      .TRC(TRC), .TRP(TRP), .TDPL(TDPL)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .sel(ba == BA_W'(g)), .op(op), .pre_all(addr_ap),
      .ap_en(ap_en), .bl_len(bl_len),
      .is_open(bank_open[g]), .rcd_done(rcd_done[g]),
      .rc_done(rc_done[g]), .rp_done(rp_done[g]),
      .ap_busy(ap_busy[g]), .ras_left(ras_left[g])
    );
  end

  sdram_rule_check #(
    .BANKS(BANKS), .BA_W(BA_W), .CNT_W(CNT_W), .BL_W(BL_W), .TDPL(TDPL)
  ) u_rules (
    .op(op), .ba(ba), .ap_req(addr_ap), .full_page(full_page),
    .bl_len(bl_len), .bank_open(bank_open), .rcd_done(rcd_done),
    .rc_done(rc_done), .rp_done(rp_done), .ap_busy(ap_busy),
    .ras_left(ras_left), .rrd_busy(rrd_c != '0), .last_act(last_act),
    .code(code), .bank(code_bank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_code  <= 4'd0;
      err_bank  <= '0;
    end else begin
      err_valid <= (code != E_NONE);
      err_code  <= code;
      err_bank  <= (code != E_NONE) ? code_bank : '0;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int BA_W  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input op_e             op,
  input logic [BA_W-1:0] ba,
  input logic            addr_ap,
  input logic [BANKS-1:0] bank_open,
  input logic [BANKS-1:0] ap_busy,
  input logic            err_valid,
  input logic [3:0]      err_code
);
  // R1: deselect never produces a report
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !err_valid);

  // R3: activate to an open bank
  a_r3_act_open: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ACT && bank_open[ba]) |=> (err_valid && err_code == 4'd1));

  // R6: plain column access to a closed, unlocked bank
  a_r6_rw_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_RD || op == OP_WR) && !addr_ap && !bank_open[ba] && !ap_busy[ba])
      |=> (err_valid && err_code == 4'd5));

  // R9: access to a bank inside its auto-precharge burst
  a_r9_ap_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_RD || op == OP_WR || op == OP_PRE) && !addr_ap && ap_busy[ba])
      |=> (err_valid && err_code == 4'd9));

  // R12: refresh with an open bank
  a_r12_ref_open: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_REF && (|bank_open)) |=> (err_valid && err_code == 4'd10));

  // R2: a report always carries a nonzero code
  a_r2_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code != 4'd0));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BANKS(BANKS), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op(op), .ba(ba),
  .addr_ap(addr_ap), .bank_open(bank_open), .ap_busy(ap_busy),
  .err_valid(err_valid), .err_code(err_code)
);

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] K_ACT = 3'b011;
  localparam logic [2:0] K_RD  = 3'b101;
  localparam logic [2:0] K_WR  = 3'b100;
  localparam logic [2:0] K_PRE = 3'b010;
  localparam logic [2:0] K_REF = 3'b001;
  localparam logic [2:0] K_MRS = 3'b000;
  localparam logic [2:0] K_NOP = 3'b111;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       cs_n = 1'b1;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic       addr_ap = 1'b0;
  logic [2:0] mode_bl = '0;
  logic       err_valid;
  logic [3:0] err_code;
  logic [1:0] err_bank;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr_ap(addr_ap),
    .mode_bl(mode_bl), .err_valid(err_valid), .err_code(err_code),
    .err_bank(err_bank)
  );

  // drive one command at a falling edge; outputs seen at the next falling edge
  task automatic step(input logic [2:0] k, input logic [1:0] b,
                      input logic ap, input logic [2:0] bl,
                      input logic csn, input logic ck);
    cs_n = csn; {ras_n, cas_n, we_n} = k; ba = b; addr_ap = ap;
    mode_bl = bl; cke = ck;
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = K_NOP; addr_ap = 1'b0; cke = 1'b1;
  endtask

  task automatic cmd(input logic [2:0] k, input logic [1:0] b, input logic ap);
    step(k, b, ap, 3'd0, 1'b0, 1'b1);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) cmd(K_NOP, 2'd0, 1'b0);
  endtask

  task automatic expect_err(input string req, input logic v,
                            input logic [3:0] c, input logic [1:0] b);
    n_checks++;
    if (err_valid !== v || (v && (err_code !== c || err_bank !== b)) ||
        (!v && err_code !== 4'd0)) begin
      n_fails++;
      $display("FAIL %s: got valid=%0b code=%0d bank=%0d, expected valid=%0b code=%0d bank=%0d",
               req, err_valid, err_code, err_bank, v, c, b);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    cs_n = 1'b1; {ras_n, cas_n, we_n} = K_NOP; cke = 1'b1; addr_ap = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nops(1);
  endtask

  task automatic t_reset_state;
    do_reset();
    expect_err("R2 reset", 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_legal_flow;  // R6 R7 R4 boundaries met
    do_reset();
    cmd(K_ACT, 2'd0, 1'b0); nops(1);
    cmd(K_RD, 2'd0, 1'b0);  expect_err("R6 read at TRCD", 1'b0, 4'd0, 2'd0);
    nops(2);
    cmd(K_PRE, 2'd0, 1'b0); expect_err("R7 precharge at TRAS", 1'b0, 4'd0, 2'd0);
    nops(1);
    cmd(K_ACT, 2'd0, 1'b0); expect_err("R4 activate at TRC", 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_deselect;  // R1
    do_reset();
    step(K_ACT, 2'd0, 1'b0, 3'd0, 1'b1, 1'b1);
    expect_err("R1 deselect", 1'b0, 4'd0, 2'd0);
    cmd(K_RD, 2'd0, 1'b0);
    expect_err("R1 deselect opened nothing", 1'b1, 4'd5, 2'd0);
  endtask

  task automatic t_act_open;  // R3 R2
    do_reset();
    cmd(K_ACT, 2'd1, 1'b0); nops(1);
    cmd(K_ACT, 2'd1, 1'b0); expect_err("R3 activate open bank", 1'b1, 4'd1, 2'd1);
    nops(1);                expect_err("R2 single-cycle pulse", 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_act_spacing;  // R4
    do_reset();
    cmd(K_ACT, 2'd2, 1'b0); nops(4);
    cmd(K_PRE, 2'd2, 1'b0);
    cmd(K_ACT, 2'd2, 1'b0); expect_err("R4 TRC same bank", 1'b1, 4'd2, 2'd2);
    do_reset();
    cmd(K_ACT, 2'd0, 1'b0);
    cmd(K_ACT, 2'd1, 1'b0); expect_err("R4 TRRD other bank", 1'b1, 4'd3, 2'd1);
    nops(1);
    cmd(K_ACT, 2'd2, 1'b0); expect_err("R4 TRRD met", 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_act_trp;  // R5
    do_reset();
    cmd(K_ACT, 2'd3, 1'b0); nops(5);
    cmd(K_PRE, 2'd3, 1'b0);
    cmd(K_ACT, 2'd3, 1'b0); expect_err("R5 TRP short", 1'b1, 4'd4, 2'd3);
  endtask

  task automatic t_rw_rules;  // R6
    do_reset();
    cmd(K_RD, 2'd0, 1'b0);  expect_err("R6 read closed bank", 1'b1, 4'd5, 2'd0);
    cmd(K_ACT, 2'd0, 1'b0);
    cmd(K_WR, 2'd0, 1'b0);  expect_err("R6 write before TRCD", 1'b1, 4'd6, 2'd0);
  endtask

  task automatic t_precharge;  // R7 R13
    do_reset();
    cmd(K_ACT, 2'd1, 1'b0); nops(1);
    cmd(K_PRE, 2'd1, 1'b0); expect_err("R7 precharge before TRAS", 1'b1, 4'd7, 2'd1);
    do_reset();
    cmd(K_ACT, 2'd0, 1'b0); nops(1);
    cmd(K_ACT, 2'd2, 1'b0); nops(3);
    cmd(K_PRE, 2'd0, 1'b1); expect_err("R7 precharge-all TRAS", 1'b1, 4'd7, 2'd2);
    nops(2);
    cmd(K_ACT, 2'd2, 1'b0); expect_err("R13 precharge-all closed banks", 1'b0, 4'd0, 2'd0);
    cmd(K_PRE, 2'd3, 1'b0); expect_err("R7 precharge closed bank", 1'b0, 4'd0, 2'd0);
    cmd(K_ACT, 2'd3, 1'b0); expect_err("R7 closed precharge no wait", 1'b0, 4'd0, 2'd0);
    do_reset();
    cmd(K_ACT, 2'd0, 1'b0); nops(1);
    cmd(K_ACT, 2'd1, 1'b0); nops(4);
    cmd(K_PRE, 2'd0, 1'b0); expect_err("R7 single precharge", 1'b0, 4'd0, 2'd0);
    cmd(K_RD, 2'd1, 1'b0);  expect_err("R7 other bank left open", 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_full_page;  // R8 R14 R13
    do_reset();
    step(K_MRS, 2'd0, 1'b0, 3'd7, 1'b0, 1'b1);
    cmd(K_ACT, 2'd0, 1'b0); nops(1);
    cmd(K_RD, 2'd0, 1'b1);  expect_err("R8 full-page auto-precharge", 1'b1, 4'd8, 2'd0);
    cmd(K_RD, 2'd0, 1'b0);  expect_err("R13 bank still open", 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_ap_lock;  // R9
    do_reset();
    cmd(K_ACT, 2'd0, 1'b0); nops(2);
    cmd(K_RD, 2'd0, 1'b1);  expect_err("R9 read auto-precharge legal", 1'b0, 4'd0, 2'd0);
    cmd(K_RD, 2'd0, 1'b0);  expect_err("R9 read in lock", 1'b1, 4'd9, 2'd0);
    cmd(K_PRE, 2'd0, 1'b0); expect_err("R9 precharge in lock", 1'b1, 4'd9, 2'd0);
    nops(1);
    cmd(K_RD, 2'd0, 1'b0);  expect_err("R9 lock ended, bank closed", 1'b1, 4'd5, 2'd0);
  endtask

  task automatic t_write_ap(input int gap, input logic bad);  // R10
    do_reset();
    cmd(K_ACT, 2'd1, 1'b0); nops(1);
    cmd(K_WR, 2'd1, 1'b1);  nops(gap - 1);
    cmd(K_ACT, 2'd1, 1'b0);
    if (bad) expect_err("R10 write-AP recovery short", 1'b1, 4'd4, 2'd1);
    else     expect_err("R10 write-AP recovery met", 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_ap_tras;  // R11 R14
    do_reset();
    step(K_MRS, 2'd0, 1'b0, 3'd0, 1'b0, 1'b1);
    cmd(K_ACT, 2'd2, 1'b0); nops(1);
    cmd(K_RD, 2'd2, 1'b1);  expect_err("R11 auto-precharge TRAS", 1'b1, 4'd7, 2'd2);
  endtask

  task automatic t_refresh;  // R12 R1
    do_reset();
    cmd(K_REF, 2'd0, 1'b0); expect_err("R12 refresh all idle", 1'b0, 4'd0, 2'd0);
    do_reset();
    cmd(K_ACT, 2'd0, 1'b0);
    step(K_REF, 2'd0, 1'b0, 3'd0, 1'b0, 1'b0);
    expect_err("R12 self-refresh with open bank", 1'b1, 4'd10, 2'd0);
    cmd(K_ACT, 2'd0, 1'b0); expect_err("R1 cke low previous cycle", 1'b0, 4'd0, 2'd0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_legal_flow();
    t_deselect();
    t_act_open();
    t_act_spacing();
    t_act_trp();
    t_rw_rules();
    t_precharge();
    t_full_page();
    t_ap_lock();
    t_write_ap(5, 1'b1);
    t_write_ap(6, 1'b0);
    t_ap_tras();
    t_refresh();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
    end
  end
endmodule